// File: doc/BRIEF.md
# Paced EEPROM Page-Write Sequencer

This block writes a short run of bytes into one page of a parallel EEPROM through a port of a shared memory bus. A start strobe gives a base address and a byte count. The block pulls the bytes one at a time from a valid/ready source and issues one bus write per byte, at consecutive addresses.

The EEPROM needs far more time between write strobes than a bare bus access provides. The sequencer therefore holds off each byte until two microsecond ticks have arrived since the previous write finished. In the gaps it leaves the bus free for lower-priority requesters. With an uncontested bus, this pacing gives roughly two microseconds per byte.

The device also commits the page to its cells by itself if writes stop for too long. A watchdog counts ticks after each completed write. If the limit is reached before the next write completes, the block aborts the page and raises an error flag. A busy level is provided for a status register. A one-cycle done pulse marks a clean finish. A synchronous abort input drops everything at once.

Top module: `ee_page_writer`

## Requirements
- R1: After reset, busy_o, done_o, bus_req_o, src_ready_o and err_o are all low.
- R2: A start_i is accepted only in the idle state, and only if count_i is non-zero and offset + count_i <= PAGE_BYTES. The offset is the low log2(PAGE_BYTES) bits of base_addr_i. A start that breaks this rule leaves the block idle and sets err_o from the next cycle. An accepted start clears err_o and raises busy_o in the next cycle.
- R3: After an accepted start, and after each completed write, the next bus request rises only after SPACE_TICKS (default 2) utick_i pulses have been sampled in the waiting state. Ticks sampled on the accepting edge, on the completion edge or on the edge after it do not count.
- R4: Byte k of the page is written at address base_addr_i + k. bus_req_o, bus_addr_o and bus_data_o hold steady until bus_grant_i is sampled. The request then drops, and the write completes when bus_done_i is sampled.
- R5: src_ready_o is high only while spacing has been met and the block waits for data. A byte is taken when src_valid_i and src_ready_o are both high. Byte k written is the k-th byte taken, and no request is raised while the source is not valid.
- R6: After bus_done_i of the last byte, done_o is high for exactly one cycle and busy_o is low in that same cycle. Exactly count_i writes are issued.
- R7: The gap watchdog starts after the first completed write and restarts at each completion. When GAP_TICKS (default 30) ticks have been sampled since the last completion, the block goes idle with err_o high and busy_o low, and it gives no done pulse. With 29 ticks the page continues.
- R8: When abort_i is sampled, the next cycle has busy_o, bus_req_o and src_ready_o low. No done pulse follows, and err_o is unchanged.
- R9: start_i while busy_o is high is ignored. The running page keeps its addresses and byte count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for a page write |
| base_addr_i | input | ADDR_W | First byte address |
| count_i | input | CNT_W | Number of bytes, 1..PAGE_BYTES |
| abort_i | input | 1 | Synchronous abort to idle |
| src_valid_i | input | 1 | Source byte available |
| src_data_i | input | DATA_W | Source byte |
| src_ready_o | output | 1 | Byte taken when high with src_valid_i |
| utick_i | input | 1 | One-cycle microsecond tick |
| bus_req_o | output | 1 | Bus write request |
| bus_addr_o | output | ADDR_W | Write address |
| bus_data_o | output | DATA_W | Write data |
| bus_grant_i | input | 1 | Request accepted by the arbiter |
| bus_done_i | input | 1 | Bus write finished |
| busy_o | output | 1 | Page write in progress |
| done_o | output | 1 | One-cycle pulse after the last byte |
| err_o | output | 1 | Rejected start or gap watchdog expiry |

## Verification
The bench measures how many ticks come before every request rise. It does this on a multi-byte page, so a pacer that waits one tick or three shows up directly, and so does a pacer that forgets to clear between bytes. It tries ranges that end exactly on the page boundary and one byte past it, plus a zero count. An off-by-one in the range check would reject a legal page or let a write wrap into the next page. It holds back the source, and later the grant, to catch a request raised without data or dropped before acceptance. It then stalls the bus for 29 and 30 ticks, where a watchdog that fires early or late, or still gives a done pulse, stands out. It also fires abort and a second start in mid-page.

// File: rtl/ee_pw_pkg.sv
`timescale 1ns/1ps
package ee_pw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start
    ST_PACE,   // counting spacing ticks, then taking a byte
    ST_REQ,    // bus request raised
    ST_WAIT,   // granted, waiting for completion
    ST_STEP,   // advance address and remaining count
    ST_DONE    // one-cycle finish
  } pw_state_e;
endpackage

// File: rtl/ee_tick_counter.sv
`timescale 1ns/1ps
// Saturating tick counter with synchronous clear; full_o once LIMIT ticks seen.
module ee_tick_counter #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic full_o
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign full_o = (cnt_q == W'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                 cnt_d = '0;
    else if (tick_i && !full_o) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ee_page_range.sv
`timescale 1ns/1ps
// Accepts a request only if it is non-empty and stays inside one page.
module ee_page_range #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 64,
  parameter int CNT_W      = 7
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              ok_o
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] end_pos;

  assign end_pos = SUM_W'(count_i) + SUM_W'(base_i[OFS_W-1:0]);
  assign ok_o    = (count_i != '0) && (end_pos <= SUM_W'(PAGE_BYTES));
endmodule

// File: rtl/ee_page_writer.sv
`timescale 1ns/1ps
module ee_page_writer
  import ee_pw_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 64,
  parameter int SPACE_TICKS = 2,
  parameter int GAP_TICKS   = 30,
  localparam int CNT_W      = $clog2(PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              abort_i,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_ready_o,
  input  logic              utick_i,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              bus_grant_i,
  input  logic              bus_done_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  pw_state_e         st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  rem_q;
  logic              armed_q, armed_d;
  logic              err_q, err_d;

  logic range_ok, accept, take, step, wr_done;
  logic pace_clr, pace_full, gap_full, gap_expire, in_page;

  ee_page_range #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)) u_range (
    .base_i (base_addr_i),
    .count_i(count_i),
    .ok_o   (range_ok)
  );

  ee_tick_counter #(.LIMIT(SPACE_TICKS)) u_pace (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (pace_clr),
    .tick_i(utick_i && (st_q == ST_PACE)),
    .full_o(pace_full)
  );

  ee_tick_counter #(.LIMIT(GAP_TICKS)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (wr_done || accept),
    .tick_i(utick_i),
    .full_o(gap_full)
  );

  assign in_page     = (st_q == ST_PACE) || (st_q == ST_REQ) ||
                       (st_q == ST_WAIT) || (st_q == ST_STEP);
  assign gap_expire  = armed_q && gap_full && in_page;
  assign src_ready_o = (st_q == ST_PACE) && pace_full && !abort_i && !gap_expire;
  assign take        = src_ready_o && src_valid_i;
  assign accept      = (st_q == ST_IDLE) && start_i && range_ok && !abort_i;
  assign step        = (st_q == ST_STEP) && !abort_i && !gap_expire;
  assign wr_done     = (st_q == ST_WAIT) && bus_done_i;
  assign pace_clr    = accept || step;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    armed_d = armed_q;
    err_d   = err_q;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (range_ok) begin
            st_d    = ST_PACE;
            armed_d = 1'b0;
            err_d   = 1'b0;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_PACE: if (take)        st_d = ST_REQ;
      ST_REQ:  if (bus_grant_i) st_d = ST_WAIT;
      ST_WAIT: begin
        if (bus_done_i) begin
          armed_d = 1'b1;
          st_d    = (rem_q == CNT_W'(1)) ? ST_DONE : ST_STEP;
        end
      end
      ST_STEP: st_d = ST_PACE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (gap_expire) begin
      st_d  = ST_IDLE;
      err_d = 1'b1;
    end
    if (abort_i) begin
      st_d    = ST_IDLE;
      err_d   = err_q;
      armed_d = armed_q;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
      err_q   <= err_d;
    end
  end

  // datapath registers with explicit load enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      data_q <= '0;
    end else begin
      if (accept) begin
        addr_q <= base_addr_i;
        rem_q  <= count_i;
      end else if (step) begin
        addr_q <= addr_q + ADDR_W'(1);
        rem_q  <= rem_q - CNT_W'(1);
      end
      if (take) data_q <= src_data_i;
    end
  end

  assign bus_req_o  = (st_q == ST_REQ);
  assign bus_addr_o = addr_q;
  assign bus_data_o = data_q;
  assign busy_o     = in_page;
  assign done_o     = (st_q == ST_DONE);
  assign err_o      = err_q;
endmodule

// File: rtl/ee_pw_checker.sv
`timescale 1ns/1ps
module ee_pw_checker #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SPACE_TICKS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              abort_i,
  input logic              utick_i,
  input logic              src_ready_o,
  input logic              bus_req_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_data_o,
  input logic              bus_grant_i,
  input logic              bus_done_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o
);
  // ticks since the last completion or idle start, saturating at 3
  logic [1:0] tk_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               tk_q <= 2'd0;
    else if (bus_done_i || (start_i && !busy_o)) tk_q <= 2'd0;
    else if (utick_i && (tk_q != 2'd3))       tk_q <= tk_q + 2'd1;
  end

  a_r3_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_o) |-> (32'(tk_q) >= SPACE_TICKS));

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_grant_i && !abort_i) |=> (bus_req_o || err_o));

  a_r4_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_grant_i && !abort_i) |=> ($stable(bus_addr_o) && $stable(bus_data_o)));

  a_r5_ready_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready_o |-> (busy_o && !bus_req_o));

  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o && !bus_req_o && !done_o));
endmodule

bind ee_page_writer ee_pw_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .abort_i    (abort_i),
  .utick_i    (utick_i),
  .src_ready_o(src_ready_o),
  .bus_req_o  (bus_req_o),
  .bus_addr_o (bus_addr_o),
  .bus_data_o (bus_data_o),
  .bus_grant_i(bus_grant_i),
  .bus_done_i (bus_done_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/sim_ee_page_writer.sv
`timescale 1ns/1ps
module sim_ee_page_writer;
  localparam int TICK_CYC = 200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, abort_i, src_valid_i, utick_i, bus_grant_i, bus_done_i;
  logic [15:0] base_addr_i;
  logic [6:0]  count_i;
  logic [7:0]  src_data_i;
  logic        src_ready_o, bus_req_o, busy_o, done_o, err_o;
  logic [15:0] bus_addr_o;
  logic [7:0]  bus_data_o;

  ee_page_writer u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .count_i(count_i), .abort_i(abort_i), .src_valid_i(src_valid_i),
    .src_data_i(src_data_i), .src_ready_o(src_ready_o), .utick_i(utick_i),
    .bus_req_o(bus_req_o), .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
    .bus_grant_i(bus_grant_i), .bus_done_i(bus_done_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit tick_en = 0, bus_auto = 1, finished = 0;
  int ticks_since = 0, n_rise = 0, n_wr = 0, n_done = 0, n_bdone = 0;
  int done_busy_bad = 0, done_long = 0;
  int rise_tk [0:31];
  logic [15:0] wr_addr [0:31];
  logic [7:0]  wr_data [0:31];
  bit prev_req = 0, prev_done = 0;
  logic [7:0] seed = 8'h00;
  int src_idx = 0;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial forever begin @(posedge clk); cyc++; end

  // microsecond tick
  initial forever begin
    step();
    utick_i = tick_en && ((cyc % TICK_CYC) == 50);
  end

  // bus arbiter and memory model
  initial forever begin
    step();
    if (bus_auto && bus_req_o) begin
      bus_grant_i = 1'b1;
      step(); bus_grant_i = 1'b0;
      step(); step();
      bus_done_i = 1'b1;
      step(); bus_done_i = 1'b0;
    end
  end

  // byte source: advance after each handshake
  initial forever begin
    bit take;
    @(negedge clk);
    take = src_valid_i && src_ready_o;
    step();
    if (take) begin
      src_idx++;
      src_data_i = seed + 8'(src_idx);
    end
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (bus_req_o && !prev_req && n_rise < 32) begin
      rise_tk[n_rise] = ticks_since; n_rise++;
    end
    if (bus_req_o && bus_grant_i && n_wr < 32) begin
      wr_addr[n_wr] = bus_addr_o; wr_data[n_wr] = bus_data_o; n_wr++;
    end
    if (done_o) begin
      n_done++;
      if (busy_o) done_busy_bad++;
      if (prev_done) done_long++;
    end
    if (bus_done_i) begin ticks_since = 0; n_bdone++; end
    else if (utick_i) ticks_since++;
    if (start_i && !busy_o) ticks_since = 0;
    prev_req = bus_req_o; prev_done = done_o;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic clear_logs();
    n_rise = 0; n_wr = 0; n_done = 0; n_bdone = 0; done_busy_bad = 0; done_long = 0;
  endtask

  task automatic set_source(input logic [7:0] s);
    seed = s; src_idx = 0; src_data_i = s;
  endtask

  task automatic align();
    while ((cyc % TICK_CYC) != 0) step();
  endtask

  task automatic pulse_start(input logic [15:0] base, input int cnt);
    step();
    start_i = 1'b1; base_addr_i = base; count_i = 7'(cnt);
    step();
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int g = 0;
    while (n_done == 0 && g < 20000) begin step(); g++; end
    repeat (3) step();
  endtask

  task automatic t_reset();
    check(!busy_o, "R1", "busy after reset", busy_o, 0);
    check(!done_o, "R1", "done after reset", done_o, 0);
    check(!bus_req_o, "R1", "req after reset", bus_req_o, 0);
    check(!src_ready_o, "R1", "ready after reset", src_ready_o, 0);
    check(!err_o, "R1", "err after reset", err_o, 0);
  endtask

  task automatic t_write(input logic [15:0] base, input int cnt, input logic [7:0] s);
    clear_logs(); set_source(s); src_valid_i = 1'b1;
    align();
    pulse_start(base, cnt);
    check(busy_o, "R2", "busy after accepted start", busy_o, 1);
    check(!err_o, "R2", "err cleared by accepted start", err_o, 0);
    wait_done();
    check(n_wr == cnt, "R6", "write count", n_wr, cnt);
    for (int k = 0; k < cnt && k < 32; k++) begin
      check(wr_addr[k] == base + 16'(k), "R4", "write address", wr_addr[k], base + 16'(k));
      check(wr_data[k] == s + 8'(k), "R5", "write data", wr_data[k], s + 8'(k));
      check(rise_tk[k] == 2, "R3", "ticks before request", rise_tk[k], 2);
    end
    check(n_done == 1, "R6", "done pulses", n_done, 1);
    check(done_busy_bad == 0, "R6", "busy during done", done_busy_bad, 0);
    check(done_long == 0, "R6", "done longer than one cycle", done_long, 0);
    check(!busy_o && !err_o, "R6", "idle without error", {busy_o, err_o}, 0);
  endtask

  task automatic t_reject(input logic [15:0] base, input int cnt);
    clear_logs();
    align();
    pulse_start(base, cnt);
    check(!busy_o, "R2", "busy after rejected start", busy_o, 0);
    check(err_o, "R2", "err after rejected start", err_o, 1);
    repeat (3 * TICK_CYC) step();
    check(n_rise == 0, "R2", "requests after reject", n_rise, 0);
  endtask

  task automatic t_src_stall();
    int g = 0;
    clear_logs(); set_source(8'h5A); src_valid_i = 1'b0;
    align();
    pulse_start(16'h0300, 1);
    while (!src_ready_o && g < 2000) begin step(); g++; end
    check(src_ready_o, "R5", "ready after spacing", src_ready_o, 1);
    repeat (20) step();
    check(!bus_req_o && src_ready_o, "R5", "no request without data", bus_req_o, 0);
    src_valid_i = 1'b1;
    wait_done();
    check(n_wr == 1 && wr_data[0] == 8'h5A, "R5", "stalled byte data", wr_data[0], 8'h5A);
  endtask

  task automatic t_hold_abort();
    int g = 0;
    clear_logs(); set_source(8'hC0); src_valid_i = 1'b1; bus_auto = 0;
    align();
    pulse_start(16'h0410, 2);
    while (!bus_req_o && g < 2000) begin step(); g++; end
    repeat (15) step();
    check(bus_req_o, "R4", "request held without grant", bus_req_o, 1);
    check(bus_addr_o == 16'h0410, "R4", "held address", bus_addr_o, 16'h0410);
    check(bus_data_o == 8'hC0, "R4", "held data", bus_data_o, 8'hC0);
    abort_i = 1'b1;
    step();
    abort_i = 1'b0;
    check(!busy_o && !bus_req_o && !src_ready_o, "R8", "outputs after abort",
          {busy_o, bus_req_o, src_ready_o}, 0);
    repeat (10) step();
    check(n_done == 0, "R8", "done after abort", n_done, 0);
    check(!err_o, "R8", "err after abort", err_o, 0);
    bus_auto = 1;
  endtask

  task automatic t_busy_start();
    int g = 0;
    clear_logs(); set_source(8'h30); src_valid_i = 1'b1;
    align();
    pulse_start(16'h0520, 3);
    while (n_wr < 1 && g < 5000) begin step(); g++; end
    pulse_start(16'h0600, 1);
    wait_done();
    check(n_wr == 3, "R9", "writes with second start", n_wr, 3);
    check(wr_addr[2] == 16'h0522, "R9", "last address", wr_addr[2], 16'h0522);
    check(n_done == 1, "R9", "done pulses", n_done, 1);
  endtask

  task automatic t_gap();
    int g = 0;
    clear_logs(); set_source(8'h77); src_valid_i = 1'b1;
    align();
    pulse_start(16'h0700, 2);
    while (n_bdone < 1 && g < 5000) begin step(); g++; end
    bus_auto = 0;
    g = 0;
    while (ticks_since < 29 && g < 20000) begin step(); g++; end
    repeat (10) step();
    check(!err_o && busy_o, "R7", "still running at 29 ticks", {err_o, busy_o}, 1);
    g = 0;
    while (ticks_since < 30 && g < 2000) begin step(); g++; end
    step();
    check(err_o, "R7", "err at 30 ticks", err_o, 1);
    check(!busy_o && !bus_req_o, "R7", "idle after gap expiry", {busy_o, bus_req_o}, 0);
    repeat (5) step();
    check(n_done == 0, "R7", "done after gap expiry", n_done, 0);
    bus_auto = 1;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 0; abort_i = 0; src_valid_i = 0; utick_i = 0;
    bus_grant_i = 0; bus_done_i = 0; base_addr_i = '0; count_i = '0; src_data_i = '0;
    repeat (4) step();
    rst_n = 1'b1;
    step();
    t_reset();
    tick_en = 1;
    t_write(16'h0100, 4, 8'h10);
    t_write(16'h013D, 3, 8'hA0);   // ends exactly at the page end
    t_reject(16'h013E, 3);         // one byte past the page end
    t_reject(16'h0200, 0);         // empty page
    t_src_stall();                 // also clears err (R2)
    t_hold_abort();
    t_busy_start();
    t_gap();
    summary();
  end
endmodule